// File: doc/BRIEF.md
# DDR2 Per-Bank Precharge Timing Guard

This block watches the command stream sent to a DDR2-style memory and keeps, for each of its banks, the earliest cycle at which that bank may be precharged. Reads, writes and their auto-precharge forms each set a minimum wait before a precharge. The wait is built from additive latency, write latency, burst length, the read-to-precharge time and the write recovery values. Each bank has a precharge-allowed flag. A precharge or precharge-all issued while a bank is still locked produces a one-cycle violation pulse that carries the bank index.

The block also tracks the precharge period (tRP) of each bank. It shows a busy flag that restarts on every precharge to that bank, whether single-bank or precharge-all. A memory controller can use the guard either as a scheduling hint (the allowed flags) or as a run-time protocol monitor (the violation pulse). The read-to-precharge cycle count is derived at elaboration from the picosecond parameters, rounding up.

Top module: `ddr2_pre_guard`

## Requirements
- R1: With `cmd_op` = 1 (read) or 2 (read with auto-precharge) to bank b in cycle c, `pre_ok[b]` is low from cycle c+1 until cycle c + AL + BL/2 + max(RTP,2) − 2, and high again in that cycle; BL/2 is 4 when `cfg_bl8` = 1, else 2.
- R2: With `cmd_op` = 3 (write) to bank b in cycle c, `pre_ok[b]` rises again in cycle c + WL + BL/2 + `cfg_twr`.
- R3: With `cmd_op` = 4 (write with auto-precharge) to bank b in cycle c, `pre_ok[b]` rises again in cycle c + WL + BL/2 + `cfg_wr`.
- R4: RTP in cycles is the ceiling of TRTP_PS / TCK_PS, never the truncated quotient.
- R5: A new access constraint never shortens a pending longer one: each bank keeps the later of its old and its new earliest-precharge cycle.
- R6: A precharge (`cmd_op` = 5) or a precharge-all (`cmd_op` = 6) places no precharge constraint of its own, so a second precharge to the same bank one cycle later raises no violation.
- R7: A single-bank precharge to bank b while `pre_ok[b]` is low raises `viol_valid` for exactly the next cycle, with `viol_bank` = b.
- R8: A precharge-all while one or more banks have `pre_ok` low raises `viol_valid` in the next cycle, with `viol_bank` set to the lowest-numbered locked bank.
- R9: A precharge of either kind to bank b in cycle c holds `rp_busy[b]` high for cycles c+1 up to c + `cfg_trp` − 1. A later precharge restarts that window.
- R10: The configuration inputs are captured only in cycles with `cmd_valid` low. A command uses the values captured at the last idle cycle before it.
- R11: After reset all `pre_ok` bits are 1, all `rp_busy` bits are 0 and `viol_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | 1 rd, 2 rd+AP, 3 wr, 4 wr+AP, 5 precharge, 6 precharge-all |
| cmd_bank | input | 3 | Target bank |
| cfg_al | input | 4 | Additive latency, cycles |
| cfg_wl | input | 4 | Write latency, cycles |
| cfg_bl8 | input | 1 | 1: burst of 8, 0: burst of 4 |
| cfg_twr | input | 5 | Write recovery for plain writes, cycles |
| cfg_wr | input | 5 | Programmed write recovery for auto-precharge writes |
| cfg_trp | input | 4 | Precharge period, cycles |
| pre_ok | output | 8 | Per bank: precharge allowed this cycle |
| rp_busy | output | 8 | Per bank: inside its precharge period |
| viol_valid | output | 1 | One-cycle pulse: the previous cycle had an early precharge |
| viol_bank | output | 3 | Bank of the reported violation |

## Verification
A bank counter left with a wrong value shows up directly on that bank's `pre_ok` bit. A counter that is too short raises the bit early, and one that is too long keeps it low, so the error is visible in the first cycle where the true deadline differs. A wrong max-merge or a configuration captured at the wrong time shows the same way, but only after a second, overlapping command. The error then also shows one cycle later as a missing or extra `viol_valid` pulse when a precharge lands in the gap. A broken tRP counter shows on `rp_busy`, no later than the cycle after a precharge.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int AL_W  = 4;
  localparam int WL_W  = 4;
  localparam int TWR_W = 5;
  localparam int WR_W  = 5;
  localparam int TRP_W = 4;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_RD   = 3'd1,
    OP_RDA  = 3'd2,
    OP_WR   = 3'd3,
    OP_WRA  = 3'd4,
    OP_PRE  = 3'd5,
    OP_PREA = 3'd6
  } pg_op_e;

  typedef struct packed {
    logic [AL_W-1:0]  al;
    logic [WL_W-1:0]  wl;
    logic             bl8;
    logic [TWR_W-1:0] twr;
    logic [WR_W-1:0]  wr;
    logic [TRP_W-1:0] trp;
  } pg_cfg_t;

  // R4: time to cycles, always rounded up
  function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/pg_delay_calc.sv
module pg_delay_calc
  import pg_pkg::*;
#(
  parameter int CNT_W   = 7,
  parameter int RTP_EFF = 3
) (
  input  pg_cfg_t          cfg,
  input  pg_op_e           op,
  output logic             is_acc,
  output logic [CNT_W-1:0] dly_m1
);
  logic [CNT_W-1:0] half_bl;
  logic [CNT_W-1:0] rd_m1, wr_m1, wra_m1;

  always_comb begin
    half_bl = cfg.bl8 ? CNT_W'(4) : CNT_W'(2);
    // one cycle is taken off because the counter reaches zero in the allowed cycle
    rd_m1   = CNT_W'(cfg.al) + half_bl + CNT_W'(RTP_EFF) - CNT_W'(3);
    wr_m1   = CNT_W'(cfg.wl) + half_bl + CNT_W'(cfg.twr) - CNT_W'(1);
    wra_m1  = CNT_W'(cfg.wl) + half_bl + CNT_W'(cfg.wr) - CNT_W'(1);
    is_acc  = 1'b1;
    unique case (op)
      OP_RD, OP_RDA: dly_m1 = rd_m1;
      OP_WR:         dly_m1 = wr_m1;
      OP_WRA:        dly_m1 = wra_m1;
      default: begin
        dly_m1 = '0;
        is_acc = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pg_bank_timer.sv
module pg_bank_timer #(
  parameter int CNT_W = 7,
  parameter int TRP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_hit,
  input  logic [CNT_W-1:0] dly_m1,
  input  logic             pre_hit,
  input  logic [TRP_W-1:0] trp,
  output logic             pre_ok,
  output logic             rp_busy
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_dec;
  logic [TRP_W-1:0] rp_q, rp_d;
  logic             cnt_en, rp_en;

  always_comb begin
    cnt_dec = (cnt_q != '0) ? cnt_q - CNT_W'(1) : '0;
    cnt_d   = cnt_dec;
    if (acc_hit && (dly_m1 > cnt_dec)) cnt_d = dly_m1;
    cnt_en  = acc_hit || (cnt_q != '0);

    if (pre_hit) rp_d = (trp != '0) ? trp - TRP_W'(1) : '0;
    else         rp_d = rp_q - TRP_W'(1);
    rp_en = pre_hit || (rp_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rp_q  <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (rp_en)  rp_q  <= rp_d;
    end
  end

  assign pre_ok  = (cnt_q == '0);
  assign rp_busy = (rp_q != '0);

  p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_hit && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_no_shorten_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && cnt_q > CNT_W'(1)) |=> (cnt_q >= $past(cnt_q) - CNT_W'(1)));
  p_rp_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pre_hit |=> (rp_busy == ($past(trp) > TRP_W'(1))));
  p_rp_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_hit && rp_q != '0) |=> (rp_q == $past(rp_q) - TRP_W'(1)));
endmodule

// File: rtl/pg_viol_pick.sv
module pg_viol_pick #(
  parameter int NB = 8,
  localparam int BW = $clog2(NB)
) (
  input  logic [NB-1:0] early,
  output logic          any,
  output logic [BW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (early[i]) begin
        any = 1'b1;
        idx = BW'(i);
      end
    end
  end
endmodule

// File: rtl/ddr2_pre_guard.sv
module ddr2_pre_guard
  import pg_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 7,
  parameter int TRTP_PS   = 7500,
  parameter int TCK_PS    = 3000,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int RTP_CYC  = int'(ceil_div(TRTP_PS, TCK_PS)),
  localparam int RTP_EFF  = (RTP_CYC < 2) ? 2 : RTP_CYC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [AL_W-1:0]      cfg_al,
  input  logic [WL_W-1:0]      cfg_wl,
  input  logic                 cfg_bl8,
  input  logic [TWR_W-1:0]     cfg_twr,
  input  logic [WR_W-1:0]      cfg_wr,
  input  logic [TRP_W-1:0]     cfg_trp,
  output logic [NUM_BANKS-1:0] pre_ok,
  output logic [NUM_BANKS-1:0] rp_busy,
  output logic                 viol_valid,
  output logic [BANK_W-1:0]    viol_bank
);
  pg_cfg_t cfg_q, cfg_d;
  pg_op_e  op;
  logic    is_acc, early_any;
  logic [CNT_W-1:0]     dly_m1;
  logic [NUM_BANKS-1:0] acc_hit, pre_hit, early;
  logic [BANK_W-1:0]    early_idx;

  assign op    = pg_op_e'(cmd_op);
  assign cfg_d = '{al: cfg_al, wl: cfg_wl, bl8: cfg_bl8, twr: cfg_twr,
                   wr: cfg_wr, trp: cfg_trp};

  // configuration is taken only while the command stream is idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= '0;
    else if (!cmd_valid) cfg_q <= cfg_d;
  end

  pg_delay_calc #(.CNT_W(CNT_W), .RTP_EFF(RTP_EFF)) u_calc (
    .cfg(cfg_q), .op(op), .is_acc(is_acc), .dly_m1(dly_m1));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign acc_hit[b] = cmd_valid && is_acc && (cmd_bank == BANK_W'(b));
    assign pre_hit[b] = cmd_valid && ((op == OP_PREA) ||
                        ((op == OP_PRE) && (cmd_bank == BANK_W'(b))));
    pg_bank_timer #(.CNT_W(CNT_W), .TRP_W(TRP_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .acc_hit(acc_hit[b]), .dly_m1(dly_m1),
      .pre_hit(pre_hit[b]), .trp(cfg_q.trp),
      .pre_ok(pre_ok[b]), .rp_busy(rp_busy[b]));
  end

  assign early = pre_hit & ~pre_ok;

  pg_viol_pick #(.NB(NUM_BANKS)) u_pick (
    .early(early), .any(early_any), .idx(early_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_bank  <= '0;
    end else begin
      viol_valid <= early_any;
      if (early_any) viol_bank <= early_idx;
    end
  end

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> $stable(cfg_q));
  p_viol_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(cmd_valid && (op == OP_PRE || op == OP_PREA)));
  p_viol_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> (($past(pre_ok) >> viol_bank) & NUM_BANKS'(1)) == '0);
  p_viol_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> ($past(early) & ((NUM_BANKS'(1) << viol_bank) - NUM_BANKS'(1))) == '0);
  p_pre_no_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !is_acc && pre_ok == '1) |=> pre_ok == '1);
endmodule

// File: tb/ddr2_pre_guard_tb.sv
module ddr2_pre_guard_tb;
  localparam int NB = 8;
  localparam int TRTP_PS = 7500;
  localparam int TCK_PS  = 3000;
  localparam int RTP  = (TRTP_PS + TCK_PS - 1) / TCK_PS;
  localparam int RTPE = (RTP < 2) ? 2 : RTP;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 0, cmd_bank = 0;
  logic [3:0] cfg_al = 0, cfg_wl = 0, cfg_trp = 0;
  logic cfg_bl8 = 0;
  logic [4:0] cfg_twr = 0, cfg_wr = 0;
  logic [NB-1:0] pre_ok, rp_busy;
  logic viol_valid;
  logic [2:0] viol_bank;

  always #5 clk = ~clk;

  ddr2_pre_guard #(.NUM_BANKS(NB), .TRTP_PS(TRTP_PS), .TCK_PS(TCK_PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cfg_al(cfg_al), .cfg_wl(cfg_wl), .cfg_bl8(cfg_bl8),
    .cfg_twr(cfg_twr), .cfg_wr(cfg_wr), .cfg_trp(cfg_trp),
    .pre_ok(pre_ok), .rp_busy(rp_busy), .viol_valid(viol_valid),
    .viol_bank(viol_bank));

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R11";
  bit done = 0;

  // behavioural model: absolute cycle numbers
  int cyc;
  int ready [NB];
  int rp_end[NB];
  int m_al, m_wl, m_bl8, m_twr, m_wr, m_trp;
  bit e_viol;
  int e_bank;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; e_viol = 0; e_bank = 0;
      m_al = 0; m_wl = 0; m_bl8 = 0; m_twr = 0; m_wr = 0; m_trp = 0;
      for (int b = 0; b < NB; b++) begin ready[b] = 0; rp_end[b] = 0; end
    end else begin
      int d, hb;
      e_viol = 0;
      hb = m_bl8 ? 4 : 2;
      if (!cmd_valid) begin
        m_al = cfg_al; m_wl = cfg_wl; m_bl8 = cfg_bl8;
        m_twr = cfg_twr; m_wr = cfg_wr; m_trp = cfg_trp;
      end else begin
        d = 0;
        case (cmd_op)
          3'd1, 3'd2: d = m_al + hb + RTPE - 2;
          3'd3:       d = m_wl + hb + m_twr;
          3'd4:       d = m_wl + hb + m_wr;
          3'd5: begin
            if (cyc < ready[cmd_bank]) begin e_viol = 1; e_bank = cmd_bank; end
            rp_end[cmd_bank] = cyc + m_trp;
          end
          3'd6: begin
            for (int b = NB - 1; b >= 0; b--) begin
              if (cyc < ready[b]) begin e_viol = 1; e_bank = b; end
              rp_end[b] = cyc + m_trp;
            end
          end
          default: ;
        endcase
        if (d > 0 && cyc + d > ready[cmd_bank]) ready[cmd_bank] = cyc + d;
      end
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NB-1:0] eok, ebusy;
      for (int b = 0; b < NB; b++) begin
        eok[b] = (cyc >= ready[b]);
        ebusy[b] = (cyc < rp_end[b]);
      end
      n_cmp++;
      if (pre_ok !== eok) begin
        n_bad++;
        $display("FAIL %s pre_ok cyc %0d: got %b exp %b", cur_req, cyc, pre_ok, eok);
      end
      n_cmp++;
      if (rp_busy !== ebusy) begin
        n_bad++;
        $display("FAIL %s rp_busy cyc %0d: got %b exp %b", cur_req, cyc, rp_busy, ebusy);
      end
      n_cmp++;
      if (viol_valid !== e_viol || (e_viol && viol_bank !== 3'(e_bank))) begin
        n_bad++;
        $display("FAIL %s viol cyc %0d: got %b/%0d exp %b/%0d", cur_req, cyc,
                 viol_valid, viol_bank, e_viol, e_bank);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired: got hang exp completion");
      finish_run();
    end
  end

  task automatic cmd(input int op, input int bank);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_bank = 3'(bank);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = 0; cmd_op = 0;
    end
  endtask

  task automatic set_cfg(input int al, input int wl, input int bl8,
                         input int twr, input int wr, input int trp);
    cfg_al = 4'(al); cfg_wl = 4'(wl); cfg_bl8 = bl8[0];
    cfg_twr = 5'(twr); cfg_wr = 5'(wr); cfg_trp = 4'(trp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R11"; idle(3);
    // R1 and R4: reads with RTP taken as a ceiling (7.5/3.0 -> 3)
    cur_req = "R1"; set_cfg(2, 3, 1, 6, 8, 5); idle(2);
    cmd(1, 1); idle(1); cmd(2, 2); idle(14);
    cur_req = "R4"; set_cfg(0, 3, 0, 6, 8, 5); idle(2);
    cmd(1, 0); idle(1); cmd(5, 0); idle(1); cmd(5, 0); idle(8);
    // R2: plain write uses cfg_twr
    cur_req = "R2"; cmd(3, 3); idle(16);
    // R3: auto-precharge write uses cfg_wr
    cur_req = "R3"; cmd(4, 4); idle(18);
    // R5: short read after long write on the same bank
    cur_req = "R5"; cmd(3, 0); cmd(1, 0); idle(18);
    // R6: back-to-back precharges, then precharge-all
    cur_req = "R6"; cmd(5, 5); cmd(5, 5); cmd(6, 0); idle(6);
    // R7: early single precharge
    cur_req = "R7"; cmd(1, 6); idle(1); cmd(5, 6); idle(10);
    // R8: precharge-all with two locked banks -> lowest reported
    cur_req = "R8"; cmd(3, 5); cmd(1, 2); cmd(6, 0); idle(20);
    // R9: tRP window restart
    cur_req = "R9"; set_cfg(0, 3, 0, 6, 8, 9); idle(2);
    cmd(5, 7); idle(2); cmd(5, 7); idle(3); cmd(6, 0); idle(12);
    // R10: configuration changed while commands keep coming
    cur_req = "R10"; set_cfg(1, 2, 0, 3, 4, 3); idle(2);
    cmd(3, 1); set_cfg(9, 9, 1, 20, 25, 12);
    cmd(3, 2); cmd(4, 3); cmd(1, 4); idle(1); cmd(3, 5); idle(40);
    // mixed stream
    cur_req = "R7";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 5) == 0) begin
        set_cfg($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 1),
                $urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 15));
      end
      if ($urandom_range(0, 2) == 0) idle(1);
      else cmd($urandom_range(0, 6), $urandom_range(0, 7));
    end
    idle(60);
    finish_run();
  end
endmodule